// File: doc/BRIEF.md
# Configurable Two-Level Sum-of-Products Array

This block evaluates a set of Boolean functions in two-level sum-of-products form. An AND plane of `N_TERM` product terms sees every input both in true and in inverted form. Each term is the AND of whichever of those literals its configuration connects. An OR plane then builds each of the `N_OUT` outputs as the OR of the terms connected to it. Every connection is a bit in a configuration register. At reset every bit is 1, meaning every connection is present. Loading a new pattern clears the connections that are not wanted.

A single mode input selects how the OR plane behaves. In shared-term mode any term may drive any number of outputs. In partitioned mode, output `o` can only see its own group of `N_TERM/N_OUT` consecutive terms, and its connection bits for all other terms are ignored. The configuration is loaded serially, one bit per clock while the load enable is high. The evaluation path from inputs to outputs is purely combinational.

Top module: `sop_array`

## Requirements
- R1: Synchronous active-high reset sets every configuration bit to 1 (all connections present). Because every term then holds both `x` and `~x`, every output reads 0 for any input.
- R2: While `cfg_load` is high, each rising clock edge shifts `cfg_bit` into the chain, and the first bit shifted lands at chain index 0 after `CHAIN_W` shifts. Chain layout: AND plane first, with term `t` at bits `t*2*N_IN +: 2*N_IN`; then the OR plane at offset `2*N_IN*N_TERM`, with output `o` at `o*N_TERM +: N_TERM` and bit `t` selecting term `t`.
- R3: While `cfg_load` is low, the configuration is held, and outputs do not change with clock edges or with `cfg_bit`.
- R4: Within a term's field, bit `2*i` connects input `i` true and bit `2*i+1` connects input `i` complemented. The term is the AND of its connected literals.
- R5: A term that has both literals of one input connected evaluates to 0.
- R6: A term with no literal connected evaluates to 0 and never asserts an output.
- R7: With `part_mode` = 0, any term may feed any set of outputs. A shared term asserts every output it is connected to, and each output is the OR of its connected terms.
- R8: With `part_mode` = 1, output `o` uses only terms `o*N_TERM/N_OUT` to `(o+1)*N_TERM/N_OUT-1`. Connections to other terms have no effect.
- R9: An output with no term connected drives 0.
- R10: Outputs follow `in_vec` combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Shift enable for the configuration chain |
| cfg_bit | input | 1 | Serial configuration data |
| part_mode | input | 1 | 0 = shared OR plane, 1 = fixed term groups per output |
| in_vec | input | N_IN | Function inputs |
| out_vec | output | N_OUT | Sum-of-products results |

## Verification
The assertions assume `rst` is high at the first clock edge. They also assume `cfg_bit` and `cfg_load` settle before each rising edge, and that outputs are only judged while `cfg_load` is low. The bench starts in reset, changes every input on the falling edge, and holds `cfg_load` low whenever it samples `out_vec`. It also assumes `N_TERM` is a multiple of `N_OUT` so that the partition groups are whole; the default sizes satisfy this.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic {OR_SHARED = 1'b0, OR_PARTITION = 1'b1} or_mode_e;
endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
  parameter int WIDTH = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             shift_in,
  output logic [WIDTH-1:0] bits
);
  always_ff @(posedge clk) begin
    if (rst) bits <= '1;
    else if (shift_en) bits <= {shift_in, bits[WIDTH-1:1]};
  end

  assert_reset_full_R1: assert property (@(posedge clk) rst |=> (&bits));
  assert_shift_entry_R2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (bits[WIDTH-1] == $past(shift_in)));
  assert_hold_cfg_R3: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(bits));
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8
) (
  input  logic [N_IN-1:0]          in_vec,
  input  logic [N_TERM*2*N_IN-1:0] conn,
  output logic [N_TERM-1:0]        terms
);
  localparam int LW = 2 * N_IN;

  logic [LW-1:0] lits;
  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      lits[2*i]   = in_vec[i];
      lits[2*i+1] = ~in_vec[i];
    end
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [LW-1:0] sel;
    assign sel      = conn[t*LW +: LW];
    assign terms[t] = (|sel) & (&(lits | ~sel));

    always_comb begin
      for (int i = 0; i < N_IN; i++) begin
        if (sel[2*i] && sel[2*i+1])
          assert_conflict_low_R5: assert (terms[t] == 1'b0);
      end
      if (sel == '0)
        assert_empty_low_R6: assert (terms[t] == 1'b0);
    end
  end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int N_TERM = 8,
  parameter int N_OUT  = 4
) (
  input  sop_pkg::or_mode_e        mode,
  input  logic [N_TERM-1:0]        terms,
  input  logic [N_OUT*N_TERM-1:0]  conn,
  output logic [N_OUT-1:0]         out_vec
);
  localparam int TPO = N_TERM / N_OUT;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_TERM-1:0] sel, grp, mask;
    assign sel = conn[o*N_TERM +: N_TERM];

    always_comb begin
      for (int t = 0; t < N_TERM; t++) grp[t] = ((t / TPO) == o);
    end

    assign mask       = (mode == sop_pkg::OR_PARTITION) ? grp : '1;
    assign out_vec[o] = |(terms & sel & mask);

    always_comb begin
      if (sel == '0)
        assert_unconnected_low_R9: assert (out_vec[o] == 1'b0);
      if (mode == sop_pkg::OR_PARTITION && (terms & sel & grp) == '0)
        assert_group_only_R8: assert (out_vec[o] == 1'b0);
    end
  end
endmodule

// File: rtl/sop_array.sv
module sop_array #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8,
  parameter int N_OUT  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic             cfg_bit,
  input  logic             part_mode,
  input  logic [N_IN-1:0]  in_vec,
  output logic [N_OUT-1:0] out_vec
);
  localparam int AND_W   = 2 * N_IN * N_TERM;
  localparam int OR_W    = N_OUT * N_TERM;
  localparam int CHAIN_W = AND_W + OR_W;

  logic [CHAIN_W-1:0] chain;
  logic [N_TERM-1:0]  terms;
  sop_pkg::or_mode_e  mode;

  assign mode = sop_pkg::or_mode_e'(part_mode);

  sop_cfg_chain #(.WIDTH(CHAIN_W)) u_chain (
    .clk(clk), .rst(rst), .shift_en(cfg_load), .shift_in(cfg_bit), .bits(chain)
  );

  sop_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .in_vec(in_vec), .conn(chain[AND_W-1:0]), .terms(terms)
  );

  sop_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .mode(mode), .terms(terms), .conn(chain[CHAIN_W-1:AND_W]), .out_vec(out_vec)
  );
endmodule

// File: tb/test_sop_array.sv
module test_sop_array;
  localparam int N_IN = 4, N_TERM = 8, N_OUT = 4;
  localparam int AND_W = 2 * N_IN * N_TERM;
  localparam int CHAIN_W = AND_W + N_OUT * N_TERM;
  // {in_vec, expected out_vec}: out0 = in0 xnor in1, out1 = in2 xor in3
  localparam logic [7:0] VEC [16] = '{
    8'h01, 8'h10, 8'h20, 8'h31, 8'h43, 8'h52, 8'h62, 8'h73,
    8'h83, 8'h92, 8'hA2, 8'hB3, 8'hC1, 8'hD0, 8'hE0, 8'hF1};

  logic clk = 0, rst = 1, cfg_load = 0, cfg_bit = 0, part_mode = 0;
  logic [N_IN-1:0] in_vec = '0;
  logic [N_OUT-1:0] out_vec;
  logic [CHAIN_W-1:0] img;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  sop_array #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) i_sop_array (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_bit(cfg_bit),
    .part_mode(part_mode), .in_vec(in_vec), .out_vec(out_vec));

  task automatic check(input logic [N_OUT-1:0] exp, input string tag);
    n_chk++;
    if (out_vec !== exp) begin
      n_bad++;
      $display("FAIL %s in=%h got %h exp %h", tag, in_vec, out_vec, exp);
    end
  endtask

  task automatic set_lit(input int t, input int i, input int comp);
    img[t*2*N_IN + 2*i + comp] = 1'b1;
  endtask

  task automatic set_or(input int o, input int t);
    img[AND_W + o*N_TERM + t] = 1'b1;
  endtask

  task automatic set_min3(input int t, input int m);
    for (int i = 0; i < 3; i++) set_lit(t, i, ((m >> i) & 1) ? 0 : 1);
  endtask

  task automatic load();
    for (int k = 0; k < CHAIN_W; k++) begin
      @(negedge clk); cfg_load = 1; cfg_bit = img[k];
    end
    @(negedge clk); cfg_load = 0; cfg_bit = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic a, b, c;
    repeat (3) @(negedge clk);
    in_vec = 4'h0; #1 check(4'h0, "R1 reset all-connected");
    in_vec = 4'hF; #1 check(4'h0, "R1 reset all-connected");
    rst = 0;

    // xnor / xor pair, terms 0,1 -> out0 and terms 2,3 -> out1
    img = '0;
    set_lit(0, 0, 0); set_lit(0, 1, 0); set_lit(1, 0, 1); set_lit(1, 1, 1);
    set_lit(2, 2, 0); set_lit(2, 3, 1); set_lit(3, 2, 1); set_lit(3, 3, 0);
    set_or(0, 0); set_or(0, 1); set_or(1, 2); set_or(1, 3);
    load();
    for (int m = 0; m < 2; m++) begin
      part_mode = logic'(m);
      for (int v = 0; v < 16; v++) begin
        @(negedge clk); in_vec = VEC[v][7:4];
        #1 check(VEC[v][3:0], m ? "R2 R4 R8 R9 vector" : "R2 R4 R7 R9 vector");
      end
    end

    // R3: clock with load low and toggling data, config must hold
    part_mode = 0; in_vec = 4'h3;
    repeat (6) begin @(negedge clk); cfg_bit = ~cfg_bit; end
    #1 check(4'h1, "R3 hold");
    // R10: input change without a clock edge
    #3 in_vec = 4'h4; #1 check(4'h3, "R10 combinational");

    // R7: AND, OR, NOR, NAND of in0..in2
    img = '0;
    set_min3(0, 7); set_or(0, 0);
    set_lit(1, 0, 0); set_lit(2, 1, 0); set_lit(3, 2, 0);
    set_or(1, 1); set_or(1, 2); set_or(1, 3);
    set_min3(4, 0); set_or(2, 4);
    set_lit(5, 0, 1); set_lit(6, 1, 1); set_lit(7, 2, 1);
    set_or(3, 5); set_or(3, 6); set_or(3, 7);
    load();
    for (int v = 0; v < 16; v++) begin
      @(negedge clk); in_vec = v[3:0];
      a = in_vec[0]; b = in_vec[1]; c = in_vec[2];
      #1 check({~(a & b & c), ~(a | b | c), a | b | c, a & b & c}, "R7 and/or/nor/nand");
    end

    // R7: XOR and XNOR of in0..in2 from minterms
    img = '0;
    set_min3(0, 1); set_min3(1, 2); set_min3(2, 4); set_min3(3, 7);
    set_min3(4, 0); set_min3(5, 3); set_min3(6, 5); set_min3(7, 6);
    for (int t = 0; t < 4; t++) begin set_or(0, t); set_or(1, t + 4); end
    load();
    for (int v = 0; v < 8; v++) begin
      @(negedge clk); in_vec = v[3:0];
      a = in_vec[0]; b = in_vec[1]; c = in_vec[2];
      #1 check({2'b00, ~(a ^ b ^ c), a ^ b ^ c}, "R7 xor/xnor");
    end

    // sharing, empty term, conflict term
    img = '0;
    set_lit(0, 0, 0); set_or(0, 0); set_or(3, 0);    // shared term in0
    set_or(1, 1);                                    // R6 empty term 1
    set_lit(2, 1, 0); set_lit(2, 1, 1); set_or(2, 2); // R5 conflict in1 & ~in1
    load();
    for (int v = 0; v < 4; v++) begin
      @(negedge clk); part_mode = 0; in_vec = v[3:0];
      #1 check({in_vec[0], 2'b00, in_vec[0]}, "R5 R6 R7 shared term");
      part_mode = 1;
      #1 check({3'b000, in_vec[0]}, "R8 out-of-group term ignored");
    end

    // R1: reset after programming restores all-connected
    @(negedge clk); rst = 1; in_vec = 4'h1;
    @(negedge clk); rst = 0;
    part_mode = 0; #1 check(4'h0, "R1 reset after load");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule